// File: doc/BRIEF.md
# SDRAM Initialization Command Sequencer

This block is the power-up command engine of an SDRAM controller. Boot software writes a small command field in which each bit asks for one SDRAM initialization command: close all banks, load the mode register, or run a burst of auto-refresh cycles. The engine places the matching command on the SDRAM control, address and bank pins, then waits out the programmed spacing. The request bit stays set for the whole time the command is in flight and drops by itself when the command is complete. Software finds out that a step has finished by reading the field until it is zero.

Normal read and write traffic, the periodic refresh scheduler and the data path belong elsewhere. The timing values and the mode word come in on configuration inputs that software loads before it starts the sequence. A typical boot writes precharge, waits for zero, writes mode-load, waits for zero, writes refresh, and waits again. A write that sets several bits at once runs them in the same fixed order.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset the command field reads zero, the chip select and the three strobes are high, and the address and bank pins are zero.
- R2: The command field sits at bits 4:2 of the register: bit 4 requests precharge-all, bit 3 requests auto-refresh and bit 2 requests mode-load. A write from idle with a nonzero field sets exactly the written bits. A write of an all-zero field changes nothing.
- R3: A precharge-all command drives cs_n=0, ras_n=0, cas_n=1 and we_n=0. On that cycle address bit 10 is high, every other address bit is low, and the bank pins are zero.
- R4: The first command appears on the pins in the second cycle after the accepted write. It lasts one cycle and is followed by t NOP cycles, where t is the delay for that step. The request bit reads zero from the cycle after the last NOP.
- R5: A mode-load command drives cs_n, ras_n, cas_n and we_n all low. The address pins carry mode_cfg bits 12:0 and the bank pins carry mode_cfg bits 14:13. It then waits t_mrd NOP cycles.
- R6: An auto-refresh request issues refresh_num refresh commands (cs_n=0, ras_n=0, cas_n=0, we_n=1). They are spaced by t_rfc NOP cycles each, and bit 3 clears only after the wait that follows the last one.
- R7: A refresh_num of zero issues the default count of 8 refresh commands.
- R8: When several bits are set together, the steps run in the order precharge, mode-load, refresh. One deselect cycle separates each finished step from the next command.
- R9: Any write while a command bit is set is ignored. The pending bits never gain a bit until the field has gone back to zero.
- R10: NOP (cs_n=0 with ras_n, cas_n and we_n high) is driven during every wait. Deselect (all four high) is driven when no command is in flight. No command is issued unless a request bit is pending.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Write strobe for the command field |
| cmd_wdata | input | 3 (bits 4:2) | Command field write data: bit 4 precharge, bit 3 refresh, bit 2 mode-load |
| cmd_rdata | output | 3 (bits 4:2) | Pending command bits, same layout |
| mode_cfg | input | 15 | Mode word: bits 12:0 to address, bits 14:13 to bank |
| t_rp | input | 4 | NOP cycles after precharge-all |
| t_mrd | input | 4 | NOP cycles after mode-load |
| t_rfc | input | 4 | NOP cycles after each auto-refresh |
| refresh_num | input | 4 | Number of refresh commands, 0 selects the default |
| sdram_cs_n | output | 1 | Chip select, active low |
| sdram_ras_n | output | 1 | Row strobe, active low |
| sdram_cas_n | output | 1 | Column strobe, active low |
| sdram_we_n | output | 1 | Write enable, active low |
| sdram_addr | output | 13 | Address pins |
| sdram_ba | output | 2 | Bank address pins |

## Verification
The hardest case to reach from the ports is a write that arrives while the engine is busy but the pins are idle. This happens in the deselect gap between two chained steps, where the command field is still nonzero yet nothing is on the bus. The bench writes all-ones into the field in exactly those gap cycles, and also in the cycle just before the first command, during a sweep over multi-bit requests. It then checks that the pin trace and the read-back follow the uninterrupted schedule. The refresh sweep covers a zero count and a zero spacing, where refresh commands run back to back with no NOP between them.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // Bit positions of the command field (software masks these three bits)
  localparam int PRE_BIT = 4;
  localparam int REF_BIT = 3;
  localparam int MRS_BIT = 2;
  localparam int FLD_HI  = PRE_BIT;
  localparam int FLD_LO  = MRS_BIT;

  typedef enum logic [2:0] {
    K_DESEL = 3'd0,
    K_NOP   = 3'd1,
    K_PRE   = 3'd2,
    K_MRS   = 3'd3,
    K_REF   = 3'd4
  } pin_kind_e;

  typedef enum logic { S_IDLE = 1'b0, S_WAIT = 1'b1 } seq_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } ctl_pins_t;

  // Control pin pattern for each bus cycle kind
  function automatic ctl_pins_t ctl_for(pin_kind_e k);
    ctl_pins_t c;
    case (k)
      K_NOP:   c = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
      K_PRE:   c = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
      K_MRS:   c = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
      K_REF:   c = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
      default: c = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    endcase
    return c;
  endfunction

  // Effective refresh count: zero selects the default
  function automatic int unsigned refresh_total(int unsigned req, int unsigned dflt);
    return (req == 0) ? dflt : req;
  endfunction

endpackage

// File: rtl/sdram_init_cmdreg.sv
module sdram_init_cmdreg
  import sdram_init_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [FLD_HI:FLD_LO] wdata,
  input  logic [2:0]           clr,      // [0] precharge, [1] mode-load, [2] refresh
  output logic [2:0]           pending,  // same order, which is also priority order
  output logic [FLD_HI:FLD_LO] rdata,
  output logic                 accept
);

  logic [2:0] req_bits;

  assign req_bits = {wdata[REF_BIT], wdata[MRS_BIT], wdata[PRE_BIT]};
  assign accept   = wr_en && (pending == 3'b000) && (req_bits != 3'b000);

  always_ff @(posedge clk) begin
    if (!rst_n)      pending <= 3'b000;
    else if (accept) pending <= req_bits;
    else             pending <= pending & ~clr;
  end

  always_comb begin
    rdata          = '0;
    rdata[PRE_BIT] = pending[0];
    rdata[MRS_BIT] = pending[1];
    rdata[REF_BIT] = pending[2];
  end

endmodule

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/sdram_init_pinreg.sv
module sdram_init_pinreg
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2,
  parameter int AP_BIT = 10,
  localparam int MODE_W = ADDR_W + BA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pin_kind_e         kind_nxt,
  input  logic [MODE_W-1:0] mode_cfg,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba
);

  localparam logic [ADDR_W-1:0] AP_MASK = {{(ADDR_W-1){1'b0}}, 1'b1} << AP_BIT;

  ctl_pins_t ctl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= ctl_for(K_DESEL);
      addr  <= '0;
      ba    <= '0;
    end else begin
      ctl_q <= ctl_for(kind_nxt);
      case (kind_nxt)
        K_MRS: begin
          addr <= mode_cfg[ADDR_W-1:0];
          ba   <= mode_cfg[MODE_W-1:ADDR_W];
        end
        K_PRE: begin
          addr <= AP_MASK;
          ba   <= '0;
        end
        default: begin
          addr <= '0;
          ba   <= '0;
        end
      endcase
    end
  end

  assign cs_n  = ctl_q.cs_n;
  assign ras_n = ctl_q.ras_n;
  assign cas_n = ctl_q.cas_n;
  assign we_n  = ctl_q.we_n;

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W          = 13,
  parameter int BA_W            = 2,
  parameter int AP_BIT          = 10,
  parameter int TW              = 4,
  parameter int CW              = 4,
  parameter int DEFAULT_REFRESH = 8,
  localparam int MODE_W = ADDR_W + BA_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_we,
  input  logic [FLD_HI:FLD_LO] cmd_wdata,
  output logic [FLD_HI:FLD_LO] cmd_rdata,
  input  logic [MODE_W-1:0]    mode_cfg,
  input  logic [TW-1:0]        t_rp,
  input  logic [TW-1:0]        t_mrd,
  input  logic [TW-1:0]        t_rfc,
  input  logic [CW-1:0]        refresh_num,
  output logic                 sdram_cs_n,
  output logic                 sdram_ras_n,
  output logic                 sdram_cas_n,
  output logic                 sdram_we_n,
  output logic [ADDR_W-1:0]    sdram_addr,
  output logic [BA_W-1:0]      sdram_ba
);

  // Named internal events
  logic [2:0]  pending;
  logic [2:0]  clr;
  logic        accept_wr;
  logic        issue_strobe;
  logic        step_done;
  logic        more_refresh;
  logic        timer_expired;
  logic [TW-1:0] issue_delay;
  logic [CW-1:0] ref_total;
  logic [CW-1:0] ref_left;
  pin_kind_e   sel_kind;
  pin_kind_e   issue_kind;
  pin_kind_e   cur_kind;
  pin_kind_e   kind_nxt;
  seq_state_e  state;

  sdram_init_cmdreg u_cmdreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cmd_we),
    .wdata   (cmd_wdata),
    .clr     (clr),
    .pending (pending),
    .rdata   (cmd_rdata),
    .accept  (accept_wr)
  );

  // Priority pick among pending requests
  always_comb begin
    if (pending[0])      sel_kind = K_PRE;
    else if (pending[1]) sel_kind = K_MRS;
    else if (pending[2]) sel_kind = K_REF;
    else                 sel_kind = K_DESEL;
  end

  assign ref_total    = CW'(refresh_total(int'(refresh_num), DEFAULT_REFRESH));
  assign more_refresh = (cur_kind == K_REF) && (ref_left > CW'(1));

  assign issue_strobe = ((state == S_IDLE) && (sel_kind != K_DESEL)) ||
                        ((state == S_WAIT) && timer_expired && more_refresh);
  assign step_done    = (state == S_WAIT) && timer_expired && !more_refresh;
  assign issue_kind   = (state == S_IDLE) ? sel_kind : K_REF;

  always_comb begin
    case (issue_kind)
      K_PRE:   issue_delay = t_rp;
      K_MRS:   issue_delay = t_mrd;
      default: issue_delay = t_rfc;
    endcase
  end

  assign clr[0] = step_done && (cur_kind == K_PRE);
  assign clr[1] = step_done && (cur_kind == K_MRS);
  assign clr[2] = step_done && (cur_kind == K_REF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cur_kind <= K_DESEL;
      ref_left <= '0;
    end else if (issue_strobe) begin
      state    <= S_WAIT;
      cur_kind <= issue_kind;
      ref_left <= (state == S_IDLE) ? ref_total : ref_left - 1'b1;
    end else if (step_done) begin
      state    <= S_IDLE;
      cur_kind <= K_DESEL;
    end
  end

  sdram_init_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (issue_strobe),
    .load_val (issue_delay),
    .expired  (timer_expired)
  );

  assign kind_nxt = issue_strobe ? issue_kind :
                    ((state == S_WAIT) && !step_done) ? K_NOP : K_DESEL;

  sdram_init_pinreg #(.ADDR_W(ADDR_W), .BA_W(BA_W), .AP_BIT(AP_BIT)) u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .kind_nxt (kind_nxt),
    .mode_cfg (mode_cfg),
    .cs_n     (sdram_cs_n),
    .ras_n    (sdram_ras_n),
    .cas_n    (sdram_cas_n),
    .we_n     (sdram_we_n),
    .addr     (sdram_addr),
    .ba       (sdram_ba)
  );

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2,
  parameter int AP_BIT = 10,
  localparam int MODE_W = ADDR_W + BA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        pending,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic [BA_W-1:0]   ba,
  input logic [MODE_W-1:0] mode_cfg
);

  localparam logic [ADDR_W-1:0] AP_MASK = {{(ADDR_W-1){1'b0}}, 1'b1} << AP_BIT;

  logic on_pre, on_mrs, on_ref, on_any;
  assign on_pre = !cs_n && !ras_n &&  cas_n && !we_n;
  assign on_mrs = !cs_n && !ras_n && !cas_n && !we_n;
  assign on_ref = !cs_n && !ras_n && !cas_n &&  we_n;
  assign on_any = !cs_n && !(ras_n && cas_n && we_n);

  // R9
  no_new_bits_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending != 3'b000) |=> ((pending & ~$past(pending)) == 3'b000));

  // R3
  precharge_a10_chk: assert property (@(posedge clk) disable iff (!rst_n)
    on_pre |-> (addr == AP_MASK && ba == '0));

  // R5
  mode_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    on_mrs |-> ({ba, addr} == $past(mode_cfg)));

  // R8
  mode_after_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    on_mrs |-> !pending[0]);

  // R8
  refresh_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    on_ref |-> (pending[1:0] == 2'b00));

  // R10
  cmd_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    on_any |-> (pending != 3'b000));

endmodule

bind sdram_init_seq sdram_init_seq_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W), .AP_BIT(AP_BIT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pending  (pending),
  .cs_n     (sdram_cs_n),
  .ras_n    (sdram_ras_n),
  .cas_n    (sdram_cas_n),
  .we_n     (sdram_we_n),
  .addr     (sdram_addr),
  .ba       (sdram_ba),
  .mode_cfg (mode_cfg)
);

// File: tb/tb_sdram_init_seq.sv
`timescale 1ns/1ps
module tb_sdram_init_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_we;
  logic [4:2]  cmd_wdata;
  logic [4:2]  cmd_rdata;
  logic [14:0] mode_cfg;
  logic [3:0]  t_rp, t_mrd, t_rfc, refresh_num;
  logic        cs_n, ras_n, cas_n, we_n;
  logic [12:0] addr;
  logic [1:0]  ba;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sdram_init_seq dut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .mode_cfg(mode_cfg), .t_rp(t_rp), .t_mrd(t_mrd),
    .t_rfc(t_rfc), .refresh_num(refresh_num), .sdram_cs_n(cs_n),
    .sdram_ras_n(ras_n), .sdram_cas_n(cas_n), .sdram_we_n(we_n),
    .sdram_addr(addr), .sdram_ba(ba)
  );

  // kind: 0 deselect, 1 NOP, 2 precharge, 3 mode-load, 4 refresh
  function automatic logic [3:0] exp_ctl(int kind);
    case (kind)
      1: return 4'b0111;
      2: return 4'b0010;
      3: return 4'b0000;
      4: return 4'b0001;
      default: return 4'b1111;
    endcase
  endfunction

  // pend order: [0] precharge, [1] mode-load, [2] refresh
  task automatic chk(string tag, int kind, logic [2:0] pend);
    logic [3:0]  ec;
    logic [12:0] ea;
    logic [1:0]  eb;
    logic [2:0]  er;
    ec = exp_ctl(kind);
    ea = (kind == 2) ? 13'h0400 : (kind == 3) ? mode_cfg[12:0] : 13'h0;
    eb = (kind == 3) ? mode_cfg[14:13] : 2'b00;
    er = {pend[0], pend[2], pend[1]};
    n_cmp++;
    if ({cs_n, ras_n, cas_n, we_n} !== ec || addr !== ea || ba !== eb || cmd_rdata !== er) begin
      n_bad++;
      $display("FAIL %s: actual ctl=%b addr=%h ba=%b rd=%b expected ctl=%b addr=%h ba=%b rd=%b",
               tag, {cs_n, ras_n, cas_n, we_n}, addr, ba, cmd_rdata, ec, ea, eb, er);
    end
  endtask

  // Write a field value from idle and follow the whole expected schedule.
  task automatic run(string tag, logic [4:2] fld, bit poke);
    logic [2:0] pend;
    pend = {fld[3], fld[2], fld[4]};
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = fld;
    @(negedge clk); cmd_we = poke && (pend != 0); cmd_wdata = 3'b111;
    chk(tag, 0, pend);
    for (int s = 0; s < 3; s++) begin
      int t;
      int reps;
      if (!pend[s]) continue;
      t    = (s == 0) ? int'(t_rp) : (s == 1) ? int'(t_mrd) : int'(t_rfc);
      reps = (s == 2) ? ((refresh_num == 0) ? 8 : int'(refresh_num)) : 1;
      for (int r = 0; r < reps; r++) begin
        @(negedge clk); cmd_we = 1'b0;
        chk(tag, s + 2, pend);
        for (int j = 0; j < t; j++) begin
          @(negedge clk);
          chk(tag, 1, pend);
        end
      end
      pend[s] = 1'b0;
      @(negedge clk);
      // R9: write all ones in the deselect gap while later steps still pend
      cmd_we = poke && (pend != 0); cmd_wdata = 3'b111;
      chk(tag, 0, pend);
    end
    @(negedge clk); cmd_we = 1'b0;
    chk(tag, 0, 3'b000);
  endtask

  initial begin
    rst_n = 1'b0; cmd_we = 1'b0; cmd_wdata = '0;
    mode_cfg = 15'h2326; t_rp = 0; t_mrd = 0; t_rfc = 0; refresh_num = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset", 0, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", 0, 3'b000);

    // R2: all-zero field does nothing
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = 3'b000;
    @(negedge clk); cmd_we = 1'b0;
    chk("R2 zero write", 0, 3'b000);
    @(negedge clk);
    chk("R2 zero write", 0, 3'b000);

    // R3 R4: precharge over delays
    for (int t = 0; t < 5; t++) begin
      t_rp = 4'(t);
      run("R3/R4 precharge", 3'b100, 0);
    end
    // R5: mode-load over delays and mode words
    for (int t = 0; t < 5; t++) begin
      t_mrd = 4'(t);
      mode_cfg = 15'h2326 ^ 15'(t * 15'h1357);
      run("R5 mode-load", 3'b001, 0);
    end
    // R6 R7: refresh over spacing and count (0 selects 8)
    for (int t = 0; t < 3; t++)
      for (int n = 0; n < 4; n++) begin
        t_rfc = 4'(t); refresh_num = 4'(n);
        run((n == 0) ? "R7 refresh default" : "R6 refresh", 3'b010, 0);
      end
    // R8 R9: combinations with busy-time writes
    for (int f = 1; f < 8; f++)
      for (int t = 0; t < 3; t++) begin
        t_rp = 4'(t); t_mrd = 4'((t + 1) % 3); t_rfc = 4'((t + 2) % 3);
        refresh_num = 4'(t + 1);
        mode_cfg = 15'(f * 15'h0911 + t);
        run("R8/R9 chained", 3'(f), 0);
        run("R9 ignored write R10", 3'(f), 1);
      end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R10 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule